// File: doc/BRIEF.md
# Multi-Sender Receive Aggregator with Credit Return

This block sits at the receive edge of a point-to-point link fabric. Up to `NUM_SRC` remote senders each deliver one deserialized word per cycle into their own receive lane. Every word carries a two-bit kind tag. Request and reply flits are buffered in a private FIFO per sender and per class, which gives `2*NUM_SRC` queues. Credit tokens are taken out of the stream at once and are never stored.

One round-robin arbiter drains the queues onto a single network output that uses a valid/stall handshake. Each flit that leaves a queue returns one credit to the sender it came from, as a one-cycle pulse on that sender's bit. Credit tokens from the far side are handed to the local transmit scheduler, also as one-cycle pulses. A write into a full queue should not happen while both ends keep their credits consistent, so it is dropped and latched as a sticky error.

Top module: `rx_aggregator`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `credit_ret`, `credit_in` and `overflow_err` are all zero after that edge.
- R2: The kind field of sender k is `rx_kind[2k+1:2k]`: 0 is a request flit, 1 is a reply flit, 2 is a credit token, and 3 is discarded with no effect on any output or queue.
- R3: Each queue is first-in first-out and holds `DEPTH` flits. Flits from one sender and class leave in the order they arrived.
- R4: A flit accepted at clock edge E reaches the output after edge E+1 at the earliest, when the output register is free or being emptied at that edge.
- R5: Queue index q = 2*sender + class, where class is 0 for request and 1 for reply. The arbiter grants the first non-empty queue at or after its pointer, wrapping around. After a grant the pointer moves to the granted index plus one. The pointer starts at 0.
- R6: While `out_valid` and `out_stall` are both high, the output flit, source and class stay unchanged, no queue is popped and the pointer does not move.
- R7: A flit that is loaded into the output raises `credit_ret[sender]` for exactly the first cycle that the flit is presented. No other bit is set in that cycle.
- R8: A credit token from sender k raises `credit_in[k]` for the one cycle after the edge that accepted it. The token is never queued.
- R9: A data flit that arrives while its queue was full before the edge is dropped and sets `overflow_err`. Only reset clears the flag.
- R10: `out_src` gives the sender and `out_cls` gives the class (0 request, 1 reply) of the flit on `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | NUM_SRC | Word present in each sender's lane |
| rx_kind | input | 2*NUM_SRC | Kind tag for each lane |
| rx_data | input | NUM_SRC*FLIT_W | Word payload for each lane |
| out_stall | input | 1 | Network cannot take the current flit |
| out_valid | output | 1 | Flit present on the output |
| out_data | output | FLIT_W | Output flit payload |
| out_src | output | $clog2(NUM_SRC) | Sender of the output flit |
| out_cls | output | 1 | Class of the output flit |
| credit_ret | output | NUM_SRC | One-cycle credit return for each sender |
| credit_in | output | NUM_SRC | One-cycle received credit for each sender |
| overflow_err | output | 1 | Sticky write-into-full error |

## Verification
The results fall due at different delays:
- `credit_in` and `overflow_err` follow one edge after the word is presented.
- A data flit reaches `out_data` two edges after it is presented.
- `credit_ret` rises in the same cycle as the flit it belongs to.

The bench drives inputs and compares outputs on the falling edge. A bench model is advanced once for each rising edge with the inputs just driven, so every comparison lines up with the edge that produced the result.

// File: rtl/rxagg_pkg.sv
package rxagg_pkg;
  typedef enum logic [1:0] {
    KIND_REQ = 2'd0,
    KIND_REP = 2'd1,
    KIND_CRD = 2'd2,
    KIND_RSV = 2'd3
  } flit_kind_e;
endpackage

// File: rtl/rxagg_split.sv
module rxagg_split
  import rxagg_pkg::*;
(
  input  logic       valid,
  input  flit_kind_e kind,
  output logic       push_req,
  output logic       push_rep,
  output logic       credit
);
  // Route one lane word by its tag; reserved tag goes nowhere.
  always_comb begin
    push_req = 1'b0;
    push_rep = 1'b0;
    credit   = 1'b0;
    if (valid) begin
      unique case (kind)
        KIND_REQ: push_req = 1'b1;
        KIND_REP: push_rep = 1'b1;
        KIND_CRD: credit   = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/rxagg_fifo.sv
module rxagg_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_wr, do_rd;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_wr   = push && !full;
  assign do_rd   = pop && !empty;
  assign rd_data = mem[rd_ptr];

  // Storage without reset so it maps onto RAM resources.
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  assert_full_blocks_growth_R9: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> full);
endmodule

// File: rtl/rxagg_rr_arb.sv
module rxagg_rr_arb #(
  parameter int N = 30
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  input  logic                 advance,
  output logic                 gnt_any,
  output logic [$clog2(N)-1:0] gnt_idx
);
  localparam int IDX_W = $clog2(N);

  logic [IDX_W-1:0] ptr;

  // First requester at or after the pointer, with wrap-around.
  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int off = 0; off < N; off++) begin
      int ix;
      ix = int'(ptr) + off;
      if (ix >= N) ix = ix - N;
      if (!gnt_any && req[ix]) begin
        gnt_any = 1'b1;
        gnt_idx = IDX_W'(ix);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (advance) ptr <= (gnt_idx == IDX_W'(N - 1)) ? '0 : gnt_idx + 1'b1;
  end

  assert_advance_has_grant_R5: assert property (@(posedge clk) disable iff (rst)
    advance |-> gnt_any);
  assert_ptr_held_R6: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(ptr));
endmodule

// File: rtl/rx_aggregator.sv
module rx_aggregator
  import rxagg_pkg::*;
#(
  parameter int NUM_SRC = 15,
  parameter int FLIT_W  = 32,
  parameter int DEPTH   = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_SRC-1:0]           rx_valid,
  input  logic [2*NUM_SRC-1:0]         rx_kind,
  input  logic [NUM_SRC*FLIT_W-1:0]    rx_data,
  input  logic                         out_stall,
  output logic                         out_valid,
  output logic [FLIT_W-1:0]            out_data,
  output logic [$clog2(NUM_SRC)-1:0]   out_src,
  output logic                         out_cls,
  output logic [NUM_SRC-1:0]           credit_ret,
  output logic [NUM_SRC-1:0]           credit_in,
  output logic                         overflow_err
);
  localparam int NQ    = 2 * NUM_SRC;
  localparam int IDX_W = $clog2(NQ);
  localparam int SRC_W = $clog2(NUM_SRC);

  logic [NQ-1:0]      q_push, q_pop, q_empty, q_full;
  logic [FLIT_W-1:0]  q_data [NQ];
  logic [NUM_SRC-1:0] crd_hit;
  logic               gnt_any, load, advance;
  logic [IDX_W-1:0]   gnt_idx;
  logic [SRC_W-1:0]   gnt_src;

  // One lane per sender: tag split plus a request and a reply queue.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_lane
    rxagg_split u_split (
      .valid    (rx_valid[s]),
      .kind     (flit_kind_e'(rx_kind[2*s +: 2])),
      .push_req (q_push[2*s]),
      .push_rep (q_push[2*s+1]),
      .credit   (crd_hit[s])
    );
    for (genvar c = 0; c < 2; c++) begin : g_cls
      rxagg_fifo #(.WIDTH(FLIT_W), .DEPTH(DEPTH)) u_q (
        .clk     (clk),
        .rst     (rst),
        .push    (q_push[2*s+c]),
        .wr_data (rx_data[s*FLIT_W +: FLIT_W]),
        .pop     (q_pop[2*s+c]),
        .rd_data (q_data[2*s+c]),
        .empty   (q_empty[2*s+c]),
        .full    (q_full[2*s+c])
      );
    end

    assert_credit_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      (rx_valid[s] && rx_kind[2*s +: 2] == 2'd2) |=> credit_in[s]);
  end

  rxagg_rr_arb #(.N(NQ)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (~q_empty),
    .advance (advance),
    .gnt_any (gnt_any),
    .gnt_idx (gnt_idx)
  );

  assign load    = !out_valid || !out_stall;
  assign advance = load && gnt_any;
  assign gnt_src = gnt_idx[IDX_W-1:1];

  always_comb begin
    q_pop = '0;
    if (advance) q_pop[gnt_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      out_data <= q_data[gnt_idx];
      out_src  <= gnt_src;
      out_cls  <= gnt_idx[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      credit_ret   <= '0;
      credit_in    <= '0;
      overflow_err <= 1'b0;
    end else begin
      if (load) out_valid <= gnt_any;
      credit_ret   <= advance ? (NUM_SRC'(1) << gnt_src) : '0;
      credit_in    <= crd_hit;
      overflow_err <= overflow_err | (|(q_push & q_full));
    end
  end

  assert_one_return_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(credit_ret));
  assert_return_with_flit_R7: assert property (@(posedge clk) disable iff (rst)
    (|credit_ret) |-> out_valid);
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_stall) |=> (out_valid && $stable(out_data) &&
                                  $stable(out_src) && $stable(out_cls) && credit_ret == '0));
  assert_sticky_error_R9: assert property (@(posedge clk) disable iff (rst)
    overflow_err |=> overflow_err);
endmodule

// File: tb/tb_rx_aggregator.sv
module tb_rx_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam int NS  = 15;
  localparam int FW  = 32;
  localparam int DEP = 4;
  localparam int NQ  = 2 * NS;
  localparam int SW  = $clog2(NS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0]    rx_valid = '0;
  logic [2*NS-1:0]  rx_kind  = '0;
  logic [NS*FW-1:0] rx_data  = '0;
  logic             out_stall = 1'b0;
  logic             out_valid, out_cls, overflow_err;
  logic [FW-1:0]    out_data;
  logic [SW-1:0]    out_src;
  logic [NS-1:0]    credit_ret, credit_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_aggregator #(.NUM_SRC(NS), .FLIT_W(FW), .DEPTH(DEP)) dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_data(rx_data),
    .out_stall(out_stall), .out_valid(out_valid), .out_data(out_data), .out_src(out_src),
    .out_cls(out_cls), .credit_ret(credit_ret), .credit_in(credit_in),
    .overflow_err(overflow_err)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Bench model of the requirements, stepped once per rising edge.
  logic [FW-1:0] mq [NQ][$];
  bit            m_ov, m_cls, m_ovf;
  logic [FW-1:0] m_data;
  int            m_src, m_ptr;
  logic [NS-1:0] m_cr, m_ci;

  task automatic chk(string req, longint act, longint exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    for (int q = 0; q < NQ; q++) mq[q].delete();
    m_ov = 0; m_cls = 0; m_ovf = 0; m_data = '0; m_src = 0; m_ptr = 0;
    m_cr = '0; m_ci = '0;
  endfunction

  function automatic void model_step();
    bit full_pre [NQ];
    bit found;
    int g;
    for (int q = 0; q < NQ; q++) full_pre[q] = (mq[q].size() >= DEP);
    m_cr = '0;
    if (!m_ov || !out_stall) begin                      // R4 R6
      found = 0; g = 0;
      for (int off = 0; off < NQ; off++) begin          // R5
        int ix;
        ix = (m_ptr + off) % NQ;
        if (!found && mq[ix].size() > 0) begin found = 1; g = ix; end
      end
      if (found) begin
        m_data = mq[g].pop_front();
        m_ov = 1; m_src = g / 2; m_cls = bit'(g % 2);
        m_cr = NS'(1) << m_src;                          // R7
        m_ptr = (g + 1) % NQ;
      end else m_ov = 0;
    end
    for (int k = 0; k < NS; k++) begin
      int kd;
      kd = int'(rx_kind[2*k +: 2]);
      m_ci[k] = rx_valid[k] && kd == 2;                  // R8
      if (rx_valid[k] && kd < 2) begin                   // R2
        if (full_pre[2*k+kd]) m_ovf = 1;                 // R9
        else mq[2*k+kd].push_back(rx_data[k*FW +: FW]);
      end
    end
  endfunction

  task automatic compare_all();
    chk("R4 out_valid", out_valid, m_ov);
    if (m_ov) begin
      chk("R3 out_data", out_data, m_data);
      chk("R10 out_src", out_src, m_src);
      chk("R10 out_cls", out_cls, m_cls);
    end
    chk("R7 credit_ret", credit_ret, m_cr);
    chk("R8 credit_in", credit_in, m_ci);
    chk("R9 overflow_err", overflow_err, m_ovf);
  endtask

  // One cycle: check previous edge's results, drive new inputs, advance model.
  task automatic cyc(logic [NS-1:0] v, logic [2*NS-1:0] kd, logic [NS*FW-1:0] d, logic st);
    @(negedge clk);
    compare_all();
    rx_valid = v; rx_kind = kd; rx_data = d; out_stall = st;
    model_step();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; rx_valid = '0; rx_kind = '0; rx_data = '0; out_stall = 0;
    @(negedge clk);
    rst = 0;
    model_reset();
    chk("R1 out_valid", out_valid, 0);
    chk("R1 credit_ret", credit_ret, 0);
    chk("R1 credit_in", credit_in, 0);
    chk("R1 overflow_err", overflow_err, 0);
    model_step();
  endtask

  function automatic logic [NS*FW-1:0] rand_data();
    logic [NS*FW-1:0] d;
    for (int k = 0; k < NS; k++) d[k*FW +: FW] = $urandom;
    return d;
  endfunction

  function automatic logic [2*NS-1:0] one_kind(int k, logic [1:0] kd);
    logic [2*NS-1:0] r;
    r = '0;
    r[2*k +: 2] = kd;
    return r;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (2) @(negedge clk);
    do_reset();

    // R2 R8: reserved tag and credit token leave no flit behind.
    cyc(NS'(1) << 2, one_kind(2, 2'd3), rand_data(), 0);
    cyc(NS'(1) << 3, one_kind(3, 2'd2), rand_data(), 0);
    cyc('0, '0, '0, 0);
    chk("R8 credit_in sender 3", credit_in, NS'(1) << 3);
    repeat (3) cyc('0, '0, '0, 0);
    chk("R2 no flit from reserved or credit", out_valid, 0);

    // R5: every queue loaded under stall, then drained in index order.
    cyc('1, '0, rand_data(), 1);
    cyc('1, {NS{2'b01}}, rand_data(), 1);
    cyc('0, '0, '0, 1);
    chk("R5 first grant sender", out_src, 0);
    chk("R5 first grant class", out_cls, 0);
    repeat (40) cyc('0, '0, '0, 0);

    // R9: burst into one request queue while the output is stalled.
    do_reset();
    for (int i = 0; i < DEP + 1; i++) cyc(NS'(1) << 5, one_kind(5, 2'd0), rand_data(), 1);
    cyc('0, '0, '0, 1);
    chk("R9 no error at capacity", overflow_err, 0);
    cyc(NS'(1) << 5, one_kind(5, 2'd0), rand_data(), 1);
    cyc('0, '0, '0, 1);
    chk("R9 error after write into full", overflow_err, 1);
    repeat (12) cyc('0, '0, '0, 0);
    chk("R9 error stays set", overflow_err, 1);

    // Random phases: light, heavy with stall, single-sender bursts.
    do_reset();
    for (int i = 0; i < 1500; i++) begin
      logic [NS-1:0] v;
      for (int k = 0; k < NS; k++) v[k] = ($urandom % 8) == 0;
      cyc(v, ($urandom % 4 == 0) ? {NS{2'b10}} : 30'($urandom), rand_data(), ($urandom % 5) == 0);
    end
    do_reset();
    for (int i = 0; i < 1500; i++) begin
      logic [NS-1:0] v;
      for (int k = 0; k < NS; k++) v[k] = ($urandom % 3) == 0;
      cyc(v, 30'($urandom), rand_data(), ($urandom % 2) == 0);
    end
    do_reset();
    for (int i = 0; i < 600; i++) begin
      int k;
      k = $urandom % NS;
      cyc(NS'(1) << k, one_kind(k, 2'($urandom % 3)), rand_data(), ($urandom % 4) == 0);
    end
    repeat (80) cyc('0, '0, '0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule